// File: doc/BRIEF.md
# Serial Link Master for a Sigma-Delta Converter

This block sits on the host side of a high-resolution sigma-delta converter and runs its serial link. The host issues one request at a time over a request/acknowledge port: the request carries a direction bit, a register-select bit and a 24-bit word. A write sends the word to the converter's control register. A read fetches 24 bits from either the conversion-data register or the calibration register. The block pulses an acknowledge when the transfer is over, and a read result is presented with that pulse.

On the converter side the block drives a separate frame strobe for reads and one for writes. It also drives a register-address line and a serial clock at one thirty-second of the system clock. It watches the converter's data-ready flag, which is active low. A read frame opens only after that flag has been seen low through a synchronizer. Words travel as three bytes, most significant bit first, with a short pause between bytes. Reads and writes use different clock phases. On a read, the converter changes data on the rising clock edge and the master captures on the falling edge. On a write, the master presents each bit before the rising edge and changes it on the falling edge. The data pin is split into out, enable and in signals so that the pad ring can build the shared line; the enable is high only during a write frame.

Top module: `adc_link_master`

## Requirements
- R1: After reset, both frame strobes (`rdFrameN`, `wrFrameN`) and `regAddr` are high, `serClk` is low, and `sdoEn` and `reqAck` are low.
- R2: A request (`reqValid` high) is accepted only while no transfer is in progress. Changes to `reqWrite`, `reqSel` or `reqData` during a transfer have no effect: the word written is the one present at acceptance, and no second frame starts until `reqValid` is seen high again after the acknowledge.
- R3: `regAddr` is low for the whole of a write frame. For a read it equals `reqSel` (1 = conversion-data register, 0 = calibration register) and stays constant while `rdFrameN` is low.
- R4: `rdFrameN` falls only after the synchronized `rdyN` is low. It falls no more than SYNC_STAGES+2 clock edges after `rdyN` goes low, and it never falls while `rdyN` stays high.
- R5: A read clocks in 24 bits, most significant bit first, sampling `sdiIn` just before each falling edge of `serClk`. The assembled word appears on `rspData` in the cycle that `reqAck` is high.
- R6: A write shifts `reqData` out on `sdoOut`, most significant bit first. Each bit is valid before its rising edge of `serClk` and changes only at the falling edge, and `wrFrameN` stays low across all three bytes.
- R7: `serClk` idles low and has a period of CLK_DIV clock cycles, high for CLK_DIV/2 of them. Each byte has 8 pulses, and `serClk` stays low for BYTE_GAP extra cycles between bytes. A frame strobe is therefore low for exactly 24·CLK_DIV + 2·BYTE_GAP cycles (800 with defaults), during which `serClk` is high for 384 cycles with 24 rising edges.
- R8: At the end of a frame the frame strobe and `regAddr` return high on the same edge that raises `reqAck`. `reqAck` is high for exactly one cycle per transfer.
- R9: `rspData` changes only at the end of a read. A write leaves it unchanged.
- R10: The two frame strobes are never low together, `sdoEn` is high exactly while `wrFrameN` is low, and `serClk` is low whenever both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request, held until `reqAck` |
| reqWrite | input | 1 | 1 = write control register, 0 = read |
| reqSel | input | 1 | Read target: 1 = conversion data, 0 = calibration |
| reqData | input | 24 | Word to write |
| reqAck | output | 1 | One-cycle completion pulse |
| rspData | output | 24 | Last word read |
| rdFrameN | output | 1 | Read frame strobe, active low |
| wrFrameN | output | 1 | Write frame strobe, active low |
| regAddr | output | 1 | Converter register-address line |
| rdyN | input | 1 | Converter data-ready flag, active low, asynchronous |
| serClk | output | 1 | Serial clock |
| sdoOut | output | 1 | Serial data toward converter |
| sdoEn | output | 1 | Drive enable for the shared data line |
| sdiIn | input | 1 | Serial data from converter |

## Verification
The bench models the converter. It shifts a register out on rising clock edges and captures written bits one cycle after each rising edge, so a master with the wrong phase reads or writes a shifted word. The bench targets the following corner cases:
- Data-ready already low when the request arrives, and data-ready held high for a random stretch. A master that ignores the flag opens the frame early; one that loses the flag hangs.
- Write words with only the end bits set. These expose a reversed bit order or a dropped last bit.
- A request whose fields change in the middle of a write while data-ready is low. A master that re-samples the request writes the wrong word or starts a stray read.
- Frame-length and pulse counts. These catch a wrong divider or a missing inter-byte pause.

// File: rtl/adc_link_pkg.sv
`timescale 1ns/1ps
package adc_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;    // capture request word
    logic shiftTx;   // advance transmit word (falling edge of serial clock)
    logic sampleRx;  // capture one received bit
    logic finishRd;  // last received bit: publish the word
  } linkStrb_t;

endpackage

// File: rtl/adc_link_sync.sv
`timescale 1ns/1ps
module adc_link_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RESET_VAL;
        else       q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= {STAGES{RESET_VAL}};
        else       q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adc_link_ctrl.sv
`timescale 1ns/1ps
module adc_link_ctrl import adc_link_pkg::*; #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int CLK_DIV   = 32,
  parameter int BYTE_GAP  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      reqSel,
  input  logic      drdySync,
  output logic      reqAck,
  output logic      rdFrameN,
  output logic      wrFrameN,
  output logic      regAddr,
  output logic      serClk,
  output logic      sdoEn,
  output linkStrb_t strb
);

  localparam int  HALF     = CLK_DIV / 2;
  localparam int  DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int  BIT_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int  BYTE_CW  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam bit  HAS_GAP  = (BYTE_GAP > 0);
  localparam int  GAP_W    = (BYTE_GAP > 1) ? $clog2(BYTE_GAP) : 1;
  localparam int  GAP_LAST = HAS_GAP ? BYTE_GAP - 1 : 0;

  linkState_e         state;
  logic               isWrite;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [BYTE_CW-1:0] byteCnt;
  logic [GAP_W-1:0]   gapCnt;

  logic bitEnd, lastBitOfByte, lastByte, lastBit;

  always_comb begin
    bitEnd        = (state == ST_SHIFT) && (divCnt == DIV_W'(CLK_DIV - 1));
    lastBitOfByte = (bitCnt == BIT_W'(BYTE_W - 1));
    lastByte      = (byteCnt == BYTE_CW'(NUM_BYTES - 1));
    lastBit       = bitEnd && lastBitOfByte && lastByte;
    strb.loadTx   = (state == ST_IDLE) && reqValid;
    strb.shiftTx  = bitEnd && isWrite;
    strb.sampleRx = bitEnd && !isWrite;
    strb.finishRd = lastBit && !isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWrite  <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      gapCnt   <= '0;
      reqAck   <= 1'b0;
      rdFrameN <= 1'b1;
      wrFrameN <= 1'b1;
      regAddr  <= 1'b1;
      serClk   <= 1'b0;
      sdoEn    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          reqAck <= 1'b0;
          if (reqValid) begin
            isWrite <= reqWrite;
            regAddr <= reqWrite ? 1'b0 : reqSel;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          divCnt  <= '0;
          bitCnt  <= '0;
          byteCnt <= '0;
          if (isWrite) begin
            wrFrameN <= 1'b0;
            sdoEn    <= 1'b1;
            state    <= ST_SHIFT;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!drdySync) begin
            rdFrameN <= 1'b0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (divCnt == DIV_W'(HALF - 1)) serClk <= 1'b1;
          if (bitEnd) begin
            serClk <= 1'b0;
            divCnt <= '0;
            if (lastBitOfByte) begin
              bitCnt <= '0;
              if (lastByte) begin
                rdFrameN <= 1'b1;
                wrFrameN <= 1'b1;
                regAddr  <= 1'b1;
                sdoEn    <= 1'b0;
                reqAck   <= 1'b1;
                state    <= ST_DONE;
              end else begin
                byteCnt <= byteCnt + BYTE_CW'(1);
                if (HAS_GAP) begin
                  gapCnt <= '0;
                  state  <= ST_GAP;
                end
              end
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == GAP_W'(GAP_LAST)) state <= ST_SHIFT;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        ST_DONE: begin
          reqAck <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  frames_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdFrameN && !wrFrameN));

  // R4
  rd_frame_after_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdFrameN) |-> $past(!drdySync));

  // R10
  drive_only_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn == !wrFrameN);

  // R3
  write_addr_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrFrameN |-> !regAddr);

  // R3
  read_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdFrameN && !$fell(rdFrameN)) |-> $stable(regAddr));

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R8
  ack_frames_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (rdFrameN && wrFrameN && regAddr));

  // R10
  clk_inside_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> (!rdFrameN || !wrFrameN));

endmodule

// File: rtl/adc_link_dp.sv
`timescale 1ns/1ps
module adc_link_dp import adc_link_pkg::*; #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrb_t         strb,
  input  logic [WORD_W-1:0] reqData,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic [WORD_W-1:0] rspData
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-2:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rspData <= '0;
    end else begin
      if (strb.loadTx)       txShift <= reqData;
      else if (strb.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (strb.sampleRx)     rxShift <= {rxShift[WORD_W-3:0], sdiIn};
      if (strb.finishRd)     rspData <= {rxShift, sdiIn};
    end
  end

  assign sdoOut = txShift[WORD_W-1];

  // R9
  rsp_only_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftTx |=> $stable(rspData));

endmodule

// File: rtl/adc_link_master.sv
`timescale 1ns/1ps
module adc_link_master import adc_link_pkg::*; #(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 3,
  parameter int CLK_DIV     = 32,
  parameter int BYTE_GAP    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSel,
  input  logic [WORD_W-1:0] reqData,
  output logic              reqAck,
  output logic [WORD_W-1:0] rspData,
  output logic              rdFrameN,
  output logic              wrFrameN,
  output logic              regAddr,
  input  logic              rdyN,
  output logic              serClk,
  output logic              sdoOut,
  output logic              sdoEn,
  input  logic              sdiIn
);

  logic      drdySync;
  linkStrb_t strb;

  adc_link_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rdyN),
    .dout (drdySync)
  );

  adc_link_ctrl #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .CLK_DIV   (CLK_DIV),
    .BYTE_GAP  (BYTE_GAP)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSel   (reqSel),
    .drdySync (drdySync),
    .reqAck   (reqAck),
    .rdFrameN (rdFrameN),
    .wrFrameN (wrFrameN),
    .regAddr  (regAddr),
    .serClk   (serClk),
    .sdoEn    (sdoEn),
    .strb     (strb)
  );

  adc_link_dp #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqData (reqData),
    .sdiIn   (sdiIn),
    .sdoOut  (sdoOut),
    .rspData (rspData)
  );

endmodule

// File: tb/adc_link_master_tb.sv
`timescale 1ns/1ps
module adc_link_master_tb;

  localparam int CLK_DIV  = 32;
  localparam int BYTE_GAP = 16;
  localparam int SYNC     = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSel = 1'b0;
  logic [23:0] reqData = '0;
  logic        reqAck;
  logic [23:0] rspData;
  logic        rdFrameN, wrFrameN, regAddr, serClk, sdoOut, sdoEn;
  logic        rdyN = 1'b1;
  logic        sdiIn;

  always #2.5 clk = ~clk;

  adc_link_master u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .reqData(reqData), .reqAck(reqAck), .rspData(rspData),
    .rdFrameN(rdFrameN), .wrFrameN(wrFrameN), .regAddr(regAddr), .rdyN(rdyN),
    .serClk(serClk), .sdoOut(sdoOut), .sdoEn(sdoEn), .sdiIn(sdiIn)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected-value helpers
  function automatic int expFrameCycles();
    return 24 * CLK_DIV + 2 * BYTE_GAP;
  endfunction
  function automatic logic [23:0] expRead(input bit sel, input logic [23:0] d,
                                          input logic [23:0] c);
    return sel ? d : c;
  endfunction

  // converter model
  logic [23:0] dataReg = 24'h123456, calReg = 24'h000146, ctrlReg;
  logic [23:0] rdShift, wrShift;
  logic        sclkQ, rdQ, wrQ;
  always @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0; rdQ <= 1'b1; wrQ <= 1'b1;
      rdShift <= '0; wrShift <= '0; ctrlReg <= '0; sdiIn <= 1'b0;
    end else begin
      sclkQ <= serClk; rdQ <= rdFrameN; wrQ <= wrFrameN;
      if (rdQ && !rdFrameN) rdShift <= regAddr ? dataReg : calReg;
      else if (!rdFrameN && serClk && !sclkQ) begin
        sdiIn   <= rdShift[23];
        rdShift <= {rdShift[22:0], 1'b0};
      end
      if (!wrFrameN && serClk && !sclkQ) wrShift <= {wrShift[22:0], sdoOut};
      if (!wrQ && wrFrameN) ctrlReg <= wrShift;
    end
  end

  // port monitor (cumulative counters)
  int  lowCyc = 0, hiCyc = 0, rises = 0, badAddr = 0, badOe = 0;
  int  bothLow = 0, clkOut = 0, acks = 0, badAck = 0;
  bit  prevClk = 0, prevAck = 0, prevLow = 0;
  logic expSel = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!rdFrameN || !wrFrameN) lowCyc++;
      if (serClk) hiCyc++;
      if (serClk && !prevClk) rises++;
      if (!wrFrameN && regAddr) badAddr++;
      if (!rdFrameN && (regAddr != expSel)) badAddr++;
      if (sdoEn != !wrFrameN) badOe++;
      if (!rdFrameN && !wrFrameN) bothLow++;
      if (serClk && rdFrameN && wrFrameN) clkOut++;
      if (reqAck) begin
        acks++;
        if (prevAck || !rdFrameN || !wrFrameN || !regAddr || !prevLow) badAck++;
      end
      prevClk = serClk;
      prevAck = reqAck;
      prevLow = !rdFrameN || !wrFrameN;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  int bLow, bHi, bRise, bAddr, bOe, bBoth, bOut, bAcks, bBad;
  task automatic snap();
    bLow = lowCyc; bHi = hiCyc; bRise = rises; bAddr = badAddr; bOe = badOe;
    bBoth = bothLow; bOut = clkOut; bAcks = acks; bBad = badAck;
  endtask

  task automatic frameChecks(input string kind);
    check(lowCyc - bLow == expFrameCycles(), "R7", {kind, " strobe-low cycles"},
          lowCyc - bLow, expFrameCycles());
    check(hiCyc - bHi == 12 * CLK_DIV, "R7", {kind, " clock-high cycles"},
          hiCyc - bHi, 12 * CLK_DIV);
    check(rises - bRise == 24, "R7", {kind, " clock pulses"}, rises - bRise, 24);
    check(badAddr == bAddr, "R3", {kind, " address line"}, badAddr - bAddr, 0);
    check(badOe == bOe && bothLow == bBoth && clkOut == bOut, "R10",
          {kind, " strobe/enable exclusivity"},
          (badOe - bOe) + (bothLow - bBoth) + (clkOut - bOut), 0);
    check(acks - bAcks == 1 && badAck == bBad, "R8", {kind, " single ack at frame end"},
          acks - bAcks, 1);
  endtask

  task automatic doRead(input bit sel, input int dly, input logic [23:0] val);
    logic [23:0] exp;
    int early = 0, n = 0, w = 0;
    if (sel) dataReg = val; else calReg = val;
    exp = expRead(sel, dataReg, calReg);
    snap();
    expSel = sel;
    reqValid = 1'b1; reqWrite = 1'b0; reqSel = sel; reqData = $urandom;
    if (dly == 0) rdyN = 1'b0;
    for (int i = 0; i < dly; i++) begin
      tick();
      if (!rdFrameN) early++;
    end
    check(early == 0, "R4", "read frame opened while data-ready high", early, 0);
    rdyN = 1'b0;
    while (rdFrameN && n < 40) begin tick(); n++; end
    if (dly == 0) check(n >= 1 && n <= SYNC + 2, "R4", "frame latency, flag already low", n, SYNC + 1);
    else          check(n >= 1 && n <= SYNC + 2, "R4", "frame latency after flag fall", n, SYNC + 1);
    while (!reqAck && w < 3000) begin tick(); w++; end
    reqValid = 1'b0;
    rdyN = 1'b1;
    check(rspData == exp, "R5", sel ? "read data register" : "read calibration register",
          rspData, exp);
    frameChecks("read");
    tick();
  endtask

  task automatic doWrite(input logic [23:0] word, input bit disturb);
    logic [23:0] keepRsp;
    int w = 0;
    int a0;
    keepRsp = rspData;
    snap();
    reqValid = 1'b1; reqWrite = 1'b1; reqSel = 1'b1; reqData = word;
    if (disturb) begin
      for (int i = 0; i < 200; i++) tick();
      reqData = ~word; reqWrite = 1'b0; reqSel = 1'b1; rdyN = 1'b0;
    end
    while (!reqAck && w < 3000) begin tick(); w++; end
    reqValid = 1'b0;
    rdyN = 1'b1;
    frameChecks("write");
    check(rspData == keepRsp, "R9", "write left read result unchanged", rspData, keepRsp);
    tick();
    check(ctrlReg == word, "R6", "word captured by converter", ctrlReg, word);
    if (disturb) begin
      a0 = acks;
      for (int i = 0; i < 6; i++) tick();
      check(rdFrameN && wrFrameN && acks == a0, "R2", "no frame after request changed mid-write",
            {rdFrameN, wrFrameN}, 2'b11);
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A71));
    repeat (4) @(negedge clk);
    check(rdFrameN && wrFrameN && regAddr && !serClk && !sdoEn && !reqAck, "R1",
          "pins during reset", {rdFrameN, wrFrameN, regAddr, serClk, sdoEn, reqAck}, 6'b111000);
    rstN = 1'b1;
    repeat (5) tick();
    check(rdFrameN && wrFrameN && regAddr && !serClk && !sdoEn && !reqAck, "R1",
          "idle pins after reset", {rdFrameN, wrFrameN, regAddr, serClk, sdoEn, reqAck}, 6'b111000);
    check(rspData == 24'h0, "R1", "read result after reset", rspData, 0);

    // directed corner cases
    doRead(1'b0, 5, 24'h000146);
    doRead(1'b1, 0, 24'hFFFFFF);
    doWrite(24'h800001, 1'b0);
    doWrite(24'h000000, 1'b0);
    doRead(1'b1, 37, 24'hA5C3E1);
    doWrite(24'h5A5A5A, 1'b1);
    doRead(1'b0, 1, 24'h800001);

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) doWrite(24'($urandom), r[3:1] == 3'd0);
      else      doRead(r[1], int'($urandom_range(0, 40)), 24'($urandom));
    end

    check(rdFrameN && wrFrameN && regAddr && !serClk && !sdoEn, "R1", "idle pins at end",
          {rdFrameN, wrFrameN, regAddr, serClk, sdoEn}, 5'b11100);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule